// File: doc/BRIEF.md
# Two-Wire Byte/Word Register Slave

This block is the serial front end of a small register file. It listens on a two-wire serial bus made of a clock line and a data line, and the data line is split into two pins. One pin carries what the block samples. The other is the block's open-drain output, where `1` means released. The two pins can be joined to form an ordinary shared data line, or each can be routed through its own isolator. The block recognises its 7-bit bus address, which is a fixed three-bit prefix followed by four strap bits. It then accepts a one-byte command and moves single bytes to or from the attached registers.

Four transaction kinds are served: byte write, word write, byte read and word read. Reads start with a write of the command byte, followed by a repeated start and the address with the read bit set. Word transactions are degenerate. A word read returns the same byte twice. A word write keeps only its first data byte, and the second byte is acknowledged and thrown away. Both bus lines are brought into the system clock domain through synchroniser flops. All bus behaviour is recovered from edges seen in that domain. The register side is given a register index, a one-cycle write strobe with its data, and a read data input that is sampled once per read.

Top module: `smb_reg_slave`

## Requirements
- R1: A byte whose upper seven bits equal {3'b001, strap[3:0]} (sent first bit first) and whose last bit is the direction bit (0 = write, 1 = read) is acknowledged by a low level on `sda_out` during the ninth clock.
- R2: After an address byte that does not match, `sda_out` stays high and no write strobe is produced until the next START, whatever bytes follow.
- R3: The low four bits of the command byte become `reg_addr` during the command acknowledge. The upper four bits have no effect.
- R4: A byte write produces exactly one `reg_wr` pulse, one clock wide, carrying the data byte on `reg_wdata`. The pulse comes in the same cycle the data acknowledge starts to be driven.
- R5: In a word write the second data byte is acknowledged, produces no strobe and leaves `reg_wdata` holding the first byte.
- R6: A byte read (command write, repeated START, address with read bit) returns `reg_rdata` for the selected register, MSB first. After the master's NACK, `sda_out` is released.
- R7: In a word read the second byte equals the first, even if the register contents change between the two bytes.
- R8: `sda_out` changes only while the clock line is low. It is low only in an acknowledge slot or for a read data bit that is 0. It works with `sda_in` wired to the AND of the master's data and `sda_out`.
- R9: A START seen at any point, including in the middle of a byte, restarts address reception. A STOP returns the block to idle.
- R10: After reset `sda_out` is 1, `reg_wr` is 0, and `reg_addr` and `reg_wdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data as seen by the receiver |
| strap | input | 4 | Strap bits forming the low part of the bus address |
| sda_out | output | 1 | Open-drain data drive, 1 = released |
| reg_addr | output | 4 | Selected register index |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Data that goes with the write strobe |
| reg_rdata | input | 8 | Contents of the register selected by `reg_addr` |

## Verification
The write strobe and the start of the data acknowledge are produced at the same clock-line fall, so a broken design can decouple them. Every byte write in the vector table provokes this. It is judged in two ways: the master must see its acknowledge on the wired data line, and the register model must count exactly one strobe with the first data byte. A second case is a word read whose register is changed by the bench between the two bytes. Here a reload of the read byte would land in the same slot as the repeated byte, so that test tells a fresh sample apart from a latched one.

// File: rtl/smb_pkg.sv
package smb_pkg;

  // Which byte of a transaction is being received or sent.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_CMD   = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4
  } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic [LINES-1:0] dprev
);

  // One extra flop per line keeps the previous synchronised value for edge detection.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], din[g]};
    end

    assign dout[g]  = chain[STAGES-1];
    assign dprev[g] = chain[STAGES];
  end

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  // Data moving while the clock stays high marks a bus condition.
  assign start_evt =  scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_evt  =  scl_s & scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              sda_out
);

  localparam int unsigned CW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DATA_W);      // all data bits taken in
  localparam logic [CW-1:0] ACK_END  = CW'(DATA_W + 1);  // acknowledge clock seen high

  function automatic logic addr_hit(input logic [DATA_W-1:0] rx,
                                    input logic [ADDR_W-1:0] own);
    return rx[DATA_W-1 -: ADDR_W] == own;
  endfunction

  function automatic logic [REG_AW-1:0] reg_index(input logic [DATA_W-1:0] cmd);
    return cmd[REG_AW-1:0];
  endfunction

  // Bit that goes on the line after idx bits of the byte have been clocked out.
  function automatic logic read_bit(input logic [DATA_W-1:0] b, input logic [CW-1:0] idx);
    logic [DATA_W-1:0] sh;
    sh = b << idx;
    return sh[DATA_W-1];
  endfunction

  smb_state_e        st;
  logic [CW-1:0]     bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] rbyte;
  logic              rw_q;
  logic              wr_done;
  logic              drive_low;
  logic [REG_AW-1:0] reg_addr_q;
  logic              reg_wr_q;
  logic [DATA_W-1:0] wdata_q;

  // Named events for the assertions.
  logic byte_done;
  logic ack_over;
  assign byte_done = scl_fall && (bit_cnt == ACK_SLOT) && (st != ST_IDLE);
  assign ack_over  = scl_fall && (bit_cnt == ACK_END)  && (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      rbyte      <= '0;
      rw_q       <= 1'b0;
      wr_done    <= 1'b0;
      drive_low  <= 1'b0;
      reg_addr_q <= '0;
      reg_wr_q   <= 1'b0;
      wdata_q    <= '0;
    end else begin
      reg_wr_q <= 1'b0;
      if (start_evt) begin
        st        <= ST_ADDR;
        bit_cnt   <= '0;
        drive_low <= 1'b0;
      end else if (stop_evt) begin
        st        <= ST_IDLE;
        bit_cnt   <= '0;
        drive_low <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < ACK_SLOT) begin
            shreg   <= {shreg[DATA_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (bit_cnt == ACK_SLOT) begin
            bit_cnt <= ACK_END;
            // A high level in the read acknowledge is the master's NACK.
            if (st == ST_RDATA && sda_s) st <= ST_IDLE;
          end
        end else if (byte_done) begin
          unique case (st)
            ST_ADDR: begin
              if (addr_hit(shreg, own_addr)) begin
                drive_low <= 1'b1;
                rw_q      <= shreg[0];
              end else begin
                st        <= ST_IDLE;
                drive_low <= 1'b0;
              end
            end
            ST_CMD: begin
              drive_low  <= 1'b1;
              reg_addr_q <= reg_index(shreg);
            end
            ST_WDATA: begin
              drive_low <= 1'b1;
              if (!wr_done) begin
                reg_wr_q <= 1'b1;
                wdata_q  <= shreg;
                wr_done  <= 1'b1;
              end
            end
            default: drive_low <= 1'b0;
          endcase
        end else if (ack_over) begin
          bit_cnt <= '0;
          unique case (st)
            ST_ADDR: begin
              if (rw_q) begin
                st        <= ST_RDATA;
                rbyte     <= reg_rdata;
                drive_low <= ~reg_rdata[DATA_W-1];
              end else begin
                st        <= ST_CMD;
                drive_low <= 1'b0;
              end
            end
            ST_CMD: begin
              st        <= ST_WDATA;
              wr_done   <= 1'b0;
              drive_low <= 1'b0;
            end
            ST_RDATA: drive_low <= ~rbyte[DATA_W-1];  // master acked: same byte again
            default:  drive_low <= 1'b0;
          endcase
        end else if (scl_fall && st == ST_RDATA) begin
          drive_low <= ~read_bit(rbyte, bit_cnt);
        end
      end
    end
  end

  assign sda_out   = ~drive_low;
  assign reg_addr  = reg_addr_q;
  assign reg_wr    = reg_wr_q;
  assign reg_wdata = wdata_q;

  // R8: the output line moves only while the clock is low (or on a bus condition).
  a_r8_out_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_out) |-> $past(!scl_s || start_evt || stop_evt));

  // R2: while idle the line is released.
  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> sda_out);

  // R4: the strobe lasts one cycle and comes with the acknowledge.
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r4_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !sda_out);

  // R3: the register index is taken only in the command acknowledge.
  a_r3_index_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> !sda_out);

  // R9: a START always restarts address reception.
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR && bit_cnt == '0));

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter int unsigned PREFIX_W    = 3,
  parameter logic [PREFIX_W-1:0] PREFIX = 3'b001,
  parameter int unsigned STRAP_W     = 4,
  parameter int unsigned REG_AW      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_out,
  output logic [REG_AW-1:0]  reg_addr,
  output logic               reg_wr,
  output logic [DATA_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0]  reg_rdata
);

  localparam int unsigned ADDR_W = PREFIX_W + STRAP_W;

  logic [1:0] line_s, line_q;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [ADDR_W-1:0] own_addr;

  assign own_addr = {PREFIX, strap};

  smb_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({scl_in, sda_in}),
    .dout  (line_s),
    .dprev (line_q)
  );

  smb_bus_events u_events (
    .scl_s     (line_s[1]),
    .scl_q     (line_q[1]),
    .sda_s     (line_s[0]),
    .sda_q     (line_q[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smb_proto_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .own_addr  (own_addr),
    .reg_rdata (reg_rdata),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .sda_out   (sda_out)
  );

endmodule

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;      // system clocks per quarter bus bit
  localparam int WD_CYCLES  = 150000;
  localparam logic [3:0] STRAP = 4'b1010;
  localparam logic [7:0] ADW = {3'b001, STRAP, 1'b0};
  localparam logic [7:0] ADR = {3'b001, STRAP, 1'b1};

  // kind: 0 byte write, 1 word write, 2 byte read, 3 word read
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'h03, 8'hA5, 8'h00, 8'hA5},
    {2'd0, 8'hF7, 8'h3C, 8'h00, 8'h3C},
    {2'd1, 8'h05, 8'h5A, 8'hC3, 8'h5A},
    {2'd2, 8'h03, 8'h00, 8'h00, 8'hA5},
    {2'd2, 8'h97, 8'h00, 8'h00, 8'h3C},
    {2'd3, 8'h05, 8'h00, 8'h00, 8'h5A},
    {2'd2, 8'h0F, 8'h00, 8'h00, 8'hBF},
    {2'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd2, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd0, 8'h0E, 8'hFF, 8'h00, 8'hFF},
    {2'd3, 8'h0E, 8'h00, 8'h00, 8'hFF},
    {2'd2, 8'h8A, 8'h00, 8'h00, 8'hEA}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_out, sda_in, reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  int hi_change = 0;
  int low_seen = 0;
  bit done = 1'b0;

  logic [7:0] model [16];
  logic       poke_en = 1'b0;
  logic [3:0] poke_a = '0;
  logic [7:0] poke_v = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_in    = m_sda & sda_out;   // wired line
  assign reg_rdata = model[reg_addr];

  smb_reg_slave dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (m_scl),
    .sda_in    (sda_in),
    .strap     (STRAP),
    .sda_out   (sda_out),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // Register model: preset pattern, strobed writes, bench pokes.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) model[i] <= 8'(i * 17) ^ 8'h40;
    end else begin
      if (reg_wr) begin
        model[reg_addr] <= reg_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (poke_en) model[poke_a] <= poke_v;
    end
  end

  // Line monitor: output must hold while the bus clock is high.
  logic scl_prev = 1'b1;
  logic out_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_scl && scl_prev && (sda_out !== out_prev)) hi_change++;
      if (sda_out === 1'b0) low_seen++;
    end
    scl_prev = m_scl;
    out_prev = sda_out;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b0; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b1; qw();
  endtask

  task automatic bit_cycle(input logic b, output logic r);
    m_sda = b; qw();
    m_scl = 1'b1; qw();
    r = sda_in; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_cycle(d[i], r);
    bit_cycle(1'b1, r);
    acked = ~r;
  endtask

  task automatic read_byte(input logic master_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r);
      d[i] = r;
    end
    bit_cycle(~master_ack, r);
  endtask

  task automatic write_txn(input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1,
                           input bit word, output logic ok);
    logic a0, a1, a2, a3;
    bus_start();
    write_byte(ADW, a0);
    write_byte(cmd, a1);
    write_byte(d0, a2);
    a3 = 1'b1;
    if (word) write_byte(d1, a3);
    bus_stop();
    ok = a0 & a1 & a2 & a3;
  endtask

  task automatic read_txn(input logic [7:0] cmd, input bit word, input bit poke_mid,
                          output logic [7:0] b0, output logic [7:0] b1,
                          output logic ok, output logic rel);
    logic a0, a1, a2;
    bus_start();
    write_byte(ADW, a0);
    write_byte(cmd, a1);
    bus_start();
    write_byte(ADR, a2);
    if (word) begin
      read_byte(1'b1, b0);
      if (poke_mid) begin
        poke_a = cmd[3:0]; poke_v = ~b0; poke_en = 1'b1;
        @(negedge clk); poke_en = 1'b0;
      end
      read_byte(1'b0, b1);
    end else begin
      read_byte(1'b0, b0);
      b1 = b0;
    end
    qw();
    rel = sda_out;
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  // Watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ok, rel, r;
    logic [7:0] b0, b1;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check("R10 sda_out", {31'd0, sda_out}, 32'd1);
    check("R10 reg_wr", {31'd0, reg_wr}, 32'd0);
    check("R10 reg_addr", {28'd0, reg_addr}, 32'd0);
    check("R10 reg_wdata", {24'd0, reg_wdata}, 32'd0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [7:0] cmd, d0, d1, exp;
      {kind, cmd, d0, d1, exp} = VEC[i];
      if (kind < 2) begin
        base = wr_cnt;
        write_txn(cmd, d0, d1, kind == 2'd1, ok);
        repeat (4) @(negedge clk);
        check("R1 R4 acks on write", {31'd0, ok}, 32'd1);
        check("R3 R4 register written", {24'd0, model[cmd[3:0]]}, {24'd0, exp});
        check(kind == 2'd1 ? "R5 single strobe for word" : "R4 single strobe",
              wr_cnt - base, 32'd1);
        check(kind == 2'd1 ? "R5 wdata keeps first byte" : "R4 wdata",
              {24'd0, reg_wdata}, {24'd0, d0});
      end else begin
        read_txn(cmd, kind == 2'd3, 1'b0, b0, b1, ok, rel);
        check("R1 R6 acks on read", {31'd0, ok}, 32'd1);
        check("R6 R3 read byte", {24'd0, b0}, {24'd0, exp});
        if (kind == 2'd3) check("R7 second word byte", {24'd0, b1}, {24'd0, exp});
        check("R6 released after NACK", {31'd0, rel}, 32'd1);
      end
    end

    // R7: register changes between the two bytes of a word read
    read_txn(8'h06, 1'b1, 1'b1, b0, b1, ok, rel);
    check("R7 first byte", {24'd0, b0}, 32'h00000026);   // preset of register 6
    check("R7 repeat ignores change", {24'd0, b1}, 32'h00000026);
    check("R7 model changed", {24'd0, model[6]}, 32'h000000D9);

    // R2: strap mismatch, then prefix mismatch
    base = wr_cnt;
    low_seen = 0;
    bus_start();
    write_byte({3'b001, 4'b1011, 1'b0}, ok);
    check("R2 no ack on strap mismatch", {31'd0, ok}, 32'd0);
    write_byte(8'h02, ok);
    write_byte(8'h77, r);
    check("R2 later bytes not acked", {31'd0, ok | r}, 32'd0);
    bus_stop();
    bus_start();
    write_byte({3'b101, STRAP, 1'b0}, ok);
    check("R2 no ack on prefix mismatch", {31'd0, ok}, 32'd0);
    write_byte(8'h02, r);
    write_byte(8'h77, r);
    bus_stop();
    repeat (4) @(negedge clk);
    check("R2 line never driven", low_seen, 32'd0);
    check("R2 no strobe", wr_cnt - base, 32'd0);
    check("R2 register untouched", {24'd0, model[2]}, 32'h00000062);

    // R9: START in the middle of an address byte
    bus_start();
    bit_cycle(1'b0, r); bit_cycle(1'b0, r); bit_cycle(1'b1, r); bit_cycle(1'b1, r);
    write_txn(8'h09, 8'h66, 8'h00, 1'b0, ok);
    repeat (4) @(negedge clk);
    check("R9 restart acks", {31'd0, ok}, 32'd1);
    check("R9 write after restart", {24'd0, model[9]}, 32'h00000066);

    // R8: output steady while bus clock high, released when idle
    check("R8 no change with clock high", hi_change, 32'd0);
    check("R8 released at end", {31'd0, sda_out}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule